// File: doc/BRIEF.md
# Serial Divide-by-Three Unit

This block divides a binary number by three while the number streams in, one bit per clock, most significant bit first. A small Mealy machine with three states keeps the running remainder of the bits seen so far. For each accepted bit it produces one quotient bit in the same cycle. Those bits are shifted into a parallel quotient register. The current remainder is also visible at all times as a two-bit output.

A new number starts with a start strobe. The strobe may come alone, which clears the unit, or it may come together with the first valid bit of the new number. Bits are taken only on cycles where the valid input is high, so the source may pause at any point. The quotient register is QW bits wide. For numbers longer than QW bits it keeps the low QW bits of the quotient, while the remainder is still exact. Two equivalent next-state implementations are available through a parameter: a case table or flat gate equations.

Top module: `serial_div3`

## Requirements
- R1: While `rst` is high at a clock edge, the unit goes to remainder 0 and the quotient register to 0. Both are observable one cycle later.
- R2: On an accepted bit b with current remainder r (encoded 0, 1 or 2), the next remainder is (2r + b) mod 3. In full: 0 with b=0 stays 0; 0 with b=1 goes to 1; 1 with b=0 goes to 2; 1 with b=1 goes to 0; 2 with b=0 goes to 1; 2 with b=1 stays 2.
- R3: `q_bit` is combinational and valid in the same cycle as `bit_vld`. It equals 1 exactly when 2r + b >= 3, with r taken as 0 when `start` is high. It is 0 whenever `bit_vld` is low.
- R4: On an accepted bit, the quotient register shifts toward its MSB, drops its old MSB, and takes that cycle's `q_bit` as its new LSB.
- R5: With `bit_vld` and `start` both low, the remainder and quotient hold, whatever `bit_in` does.
- R6: `start` with `bit_vld` low clears the remainder to 0 and the quotient to 0.
- R7: `start` with `bit_vld` high discards the previous number and treats `bit_in` as the first bit of a new number, starting from remainder 0 and an empty quotient.
- R8: `remainder` never shows the value 3.
- R9: After a number x of at most QW bits has been fed in, starting with a start strobe, `quotient` equals floor(x/3) and `remainder` equals x mod 3. For example, 4-bit 1111 gives 0101 with remainder 0, and 1010 gives 0011 with remainder 1.
- R10: For a number longer than QW bits, `quotient` equals floor(x/3) mod 2^QW and `remainder` equals x mod 3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Begin a new number and clear the unit |
| bit_vld | input | 1 | `bit_in` carries a valid bit this cycle |
| bit_in | input | 1 | Serial dividend bit, MSB first |
| q_bit | output | 1 | Quotient bit for the current input bit |
| quotient | output | QW | Collected quotient bits, newest bit at the LSB |
| remainder | output | 2 | Running remainder, 0 to 2 |

## Verification
The bench feeds every 8-bit value, with idle gaps inside some numbers. A design with a wrong table entry would give a wrong quotient or remainder for some value, and a design that advanced on idle cycles would shift extra zeros into the quotient. A start strobe that arrives with a valid bit in the middle of a number checks that the first bit is taken from remainder 0. A design that used the old remainder there, or dropped the bit, would give a wrong result. A 20-bit number checks that the quotient truncates to its low bits while the remainder stays exact, and a reset in mid-stream and a start strobe alone must both bring everything back to zero.

// File: rtl/div3_pkg.sv
package div3_pkg;
   typedef enum logic [1:0] {
      REM0 = 2'd0,
      REM1 = 2'd1,
      REM2 = 2'd2
   } rem_t;

   localparam int IMPL_TABLE = 0;
   localparam int IMPL_GATES = 1;
endpackage

// File: rtl/div3_step.sv
module div3_step
   import div3_pkg::*;
#(
   parameter int IMPL = IMPL_TABLE
) (
   input  rem_t cur,
   input  logic din,
   output rem_t nxt,
   output logic qb
);
   generate
      if (IMPL == IMPL_TABLE) begin : g_table
         always_comb begin
            case (cur)
               REM0: begin nxt = din ? REM1 : REM0; qb = 1'b0; end
               REM1: begin nxt = din ? REM0 : REM2; qb = din;  end
               REM2: begin nxt = din ? REM2 : REM1; qb = 1'b1; end
               default: begin nxt = REM0; qb = 1'b0; end
            endcase
         end
      end else begin : g_gates
         logic [1:0] c;
         logic [1:0] n;
         assign c    = cur;
         assign qb   = c[1] | (c[0] & din);
         assign n[1] = (c[0] & ~din) | (c[1] & din);
         assign n[0] = (~c[1] & ~c[0] & din) | (c[1] & ~din);
         assign nxt  = rem_t'(n);
      end
   endgenerate
endmodule

// File: rtl/div3_rem_reg.sv
module div3_rem_reg
   import div3_pkg::*;
(
   input  logic clk,
   input  logic rst,
   input  logic start,
   input  logic adv,
   input  rem_t nxt,
   output rem_t cur
);
   always_ff @(posedge clk) begin
      if (rst)        cur <= REM0;
      else if (adv)   cur <= nxt;
      else if (start) cur <= REM0;
   end
endmodule

// File: rtl/div3_quot_sreg.sv
module div3_quot_sreg #(
   parameter int QW = 8
) (
   input  logic          clk,
   input  logic          rst,
   input  logic          start,
   input  logic          adv,
   input  logic          qb,
   output logic [QW-1:0] q
);
   localparam logic [QW-1:0] ZERO = '0;

   logic [QW-1:0] base;
   assign base = start ? ZERO : q;

   always_ff @(posedge clk) begin
      if (rst)        q <= ZERO;
      else if (adv)   q <= {base[QW-2:0], qb};
      else if (start) q <= ZERO;
   end
endmodule

// File: rtl/serial_div3.sv
module serial_div3
   import div3_pkg::*;
#(
   parameter int QW   = 8,
   parameter int IMPL = IMPL_TABLE
) (
   input  logic          clk,
   input  logic          rst,
   input  logic          start,
   input  logic          bit_vld,
   input  logic          bit_in,
   output logic          q_bit,
   output logic [QW-1:0] quotient,
   output logic [1:0]    remainder
);
   generate
      if (QW < 2) begin : g_bad_qw
         $error("serial_div3: QW must be at least 2");
      end
      if (IMPL != IMPL_TABLE && IMPL != IMPL_GATES) begin : g_bad_impl
         $error("serial_div3: IMPL selects an unknown variant");
      end
   endgenerate

   rem_t cur, eff, nxt;
   logic qb;

   // A start strobe makes the incoming bit the first of a fresh number (R7)
   assign eff = start ? REM0 : cur;

   div3_step #(.IMPL(IMPL)) u_step (
      .cur (eff),
      .din (bit_in),
      .nxt (nxt),
      .qb  (qb)
   );

   div3_rem_reg u_rem (
      .clk   (clk),
      .rst   (rst),
      .start (start),
      .adv   (bit_vld),
      .nxt   (nxt),
      .cur   (cur)
   );

   div3_quot_sreg #(.QW(QW)) u_quot (
      .clk   (clk),
      .rst   (rst),
      .start (start),
      .adv   (bit_vld),
      .qb    (qb),
      .q     (quotient)
   );

   assign q_bit     = bit_vld & qb;
   assign remainder = cur;
endmodule

// File: rtl/serial_div3_chk.sv
module serial_div3_chk #(
   parameter int QW   = 8,
   parameter int IMPL = 0
) (
   input logic          clk,
   input logic          rst,
   input logic          start,
   input logic          bit_vld,
   input logic          bit_in,
   input logic          q_bit,
   input logic [QW-1:0] quotient,
   input logic [1:0]    remainder
);
   function automatic int acc(logic [1:0] r, logic b);
      return 2 * int'(r) + int'(b);
   endfunction

   // R2: remainder follows (2r + b) mod 3
   p_next_rem_r2: assert property (@(posedge clk) disable iff (rst)
      (bit_vld && !start) |=> int'(remainder) == acc($past(remainder), $past(bit_in)) % 3);

   // R3: quotient bit in the same cycle
   p_qbit_r3: assert property (@(posedge clk) disable iff (rst)
      (bit_vld && !start) |-> q_bit == (acc(remainder, bit_in) >= 3));

   p_qbit_idle_r3: assert property (@(posedge clk) disable iff (rst)
      !bit_vld |-> !q_bit);

   // R4: shift toward the MSB, new bit at the LSB
   p_shift_r4: assert property (@(posedge clk) disable iff (rst)
      (bit_vld && !start) |=> quotient == {$past(quotient[QW-2:0]), $past(q_bit)});

   // R5: hold while idle
   p_hold_r5: assert property (@(posedge clk) disable iff (rst)
      (!bit_vld && !start) |=> $stable(quotient) && $stable(remainder));

   // R6: start alone clears
   p_clear_r6: assert property (@(posedge clk) disable iff (rst)
      (start && !bit_vld) |=> quotient == '0 && remainder == 2'd0);

   // R7: start with a bit begins from remainder 0
   p_restart_r7: assert property (@(posedge clk) disable iff (rst)
      (start && bit_vld) |=> int'(remainder) == int'($past(bit_in))
                             && quotient == '0);

   // R8: remainder encoding 3 never appears
   p_range_r8: assert property (@(posedge clk) disable iff (rst)
      remainder != 2'd3);
endmodule

bind serial_div3 serial_div3_chk #(.QW(QW), .IMPL(IMPL)) u_chk (.*);

// File: tb/serial_div3_test.sv
`timescale 1ns/1ps
module serial_div3_test;
   localparam int QW = 8;
   localparam longint MASK = (64'd1 << QW) - 1;

   logic clk = 1'b0;
   logic rst = 1'b1;
   logic start = 1'b0;
   logic bit_vld = 1'b0;
   logic bit_in = 1'b0;
   logic q_bit;
   logic [QW-1:0] quotient;
   logic [1:0] remainder;

   int total = 0;
   int bad = 0;
   int cycles = 0;
   bit finished = 1'b0;

   int m_rem = 0;
   longint m_q = 0;

   always #2 clk = ~clk;

   serial_div3 #(.QW(QW)) uut (
      .clk(clk), .rst(rst), .start(start), .bit_vld(bit_vld), .bit_in(bit_in),
      .q_bit(q_bit), .quotient(quotient), .remainder(remainder)
   );

   task automatic check(input string tag, input longint act, input longint exp);
      total++;
      if (act != exp) begin
         bad++;
         $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
      end
   endtask

   task automatic check_regs();
      check("R2 remainder", longint'(remainder), longint'(m_rem));
      check("R4 quotient", longint'(quotient), m_q);
      check("R8 remainder range", longint'(remainder == 2'd3), 0);
   endtask

   // one clock: compare registers, drive, check q_bit, update model at the edge
   task automatic step(input bit st, input bit v, input bit b);
      int eff;
      int expq;
      @(negedge clk);
      check_regs();
      start = st; bit_vld = v; bit_in = b;
      eff = st ? 0 : m_rem;
      expq = (v && (2 * eff + int'(b) >= 3)) ? 1 : 0;
      #0.5;
      check("R3 q_bit", longint'(q_bit), longint'(expq));
      @(posedge clk);
      if (st) begin m_rem = 0; m_q = 0; end
      if (v) begin
         m_q = ((m_q << 1) | longint'(expq)) & MASK;
         m_rem = (2 * eff + int'(b)) % 3;
      end
   endtask

   task automatic feed(input longint x, input int nbits, input int gap_seed);
      for (int i = nbits - 1; i >= 0; i--) begin
         if (gap_seed != 0 && ((i + gap_seed) % 4 == 0))
            step(1'b0, 1'b0, ~x[i]);
         step(i == nbits - 1, 1'b1, x[i]);
      end
   endtask

   task automatic final_chk(input string tag, input longint x);
      #1;
      check({tag, " quotient"}, longint'(quotient), (x / 3) & MASK);
      check({tag, " remainder"}, longint'(remainder), x % 3);
   endtask

   task automatic idle();
      @(negedge clk);
      start = 1'b0; bit_vld = 1'b0; bit_in = 1'b0;
   endtask

   initial begin
      logic [QW-1:0] hq;
      logic [1:0] hr;
      rst = 1'b1;
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst = 1'b0;
      #0.5;
      check("R1 reset quotient", longint'(quotient), 0);
      check("R1 reset remainder", longint'(remainder), 0);

      // R9 examples
      feed(64'b1111, 4, 0);
      final_chk("R9 1111", 64'b1111);
      feed(64'b1010, 4, 0);
      final_chk("R9 1010", 64'b1010);

      // R5: hold with bit_in toggling while idle
      feed(64'b110, 3, 0);
      #1; hq = quotient; hr = remainder;
      step(1'b0, 1'b0, 1'b1);
      step(1'b0, 1'b0, 1'b0);
      step(1'b0, 1'b0, 1'b1);
      #1;
      check("R5 hold quotient", longint'(quotient), longint'(hq));
      check("R5 hold remainder", longint'(remainder), longint'(hr));

      // R6: start alone clears
      step(1'b1, 1'b0, 1'b1);
      #1;
      check("R6 clear quotient", longint'(quotient), 0);
      check("R6 clear remainder", longint'(remainder), 0);

      // R7: restart mid-number
      step(1'b0, 1'b1, 1'b1);
      step(1'b0, 1'b1, 1'b0);
      step(1'b0, 1'b1, 1'b1);
      feed(64'b11011, 5, 0);
      final_chk("R7 restart", 64'b11011);

      // R9: every 8-bit value, some with idle gaps
      for (int x = 0; x < 256; x++) begin
         feed(longint'(x), QW, x % 3);
         final_chk("R9 sweep", longint'(x));
      end

      // R10: number longer than the quotient register
      feed(64'hABCDE, 20, 0);
      final_chk("R10 long", 64'hABCDE);
      feed(64'hFFFFF, 20, 1);
      final_chk("R10 long ones", 64'hFFFFF);

      // R1: reset in mid-stream
      feed(64'b1011, 4, 0);
      @(negedge clk);
      rst = 1'b1; start = 1'b0; bit_vld = 1'b1; bit_in = 1'b1;
      @(posedge clk);
      m_rem = 0; m_q = 0;
      @(negedge clk);
      rst = 1'b0; bit_vld = 1'b0;
      #0.5;
      check("R1 mid reset quotient", longint'(quotient), 0);
      check("R1 mid reset remainder", longint'(remainder), 0);
      feed(64'b100, 3, 0);
      final_chk("R9 after reset", 64'b100);
      idle();
      step(1'b0, 1'b0, 1'b0);

      if (!finished) begin
         finished = 1'b1;
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      while (cycles < 100000) begin
         @(posedge clk);
         cycles++;
      end
      if (!finished) begin
         finished = 1'b1;
         total++;
         bad++;
         $display("FAIL watchdog actual=%0d expected=done", cycles);
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end
endmodule